// File: doc/BRIEF.md
# Guarded Halfword Store Unit with Selectable Byte Order

This unit executes a single 16-bit store that carries an immediate displacement. A 7-bit modifier holds a signed count of halfwords. The unit sign-extends it, doubles it and adds it to a base address to form the effective byte address. When the issue strobe is high and bit 0 of the guard word is 1, the unit places the low halfword of the source operand on two byte lanes of a 32-bit word-organised memory bus and drives a byte-enabled write request one cycle later. The order of the two bytes is chosen per operation by a byte-order control bit.

An effective address that is not a multiple of two counts as misaligned. A misaligned store writes nothing. It sets a sticky misaligned-store flag, and that flag stays set until a clear input is pulsed. If the trap enable is 1 when the flag is set, an exception request is recorded. That request is released as a one-cycle trap pulse after the next interruptible-jump strobe. A false guard leaves memory, the flag and the trap state untouched.

Top module: `hstore_unit`

## Requirements
- R1: One cycle after an accepted aligned store, `mem_addr_o` equals the effective address base + 2*sext(mod), computed modulo 2^32, with its two low bits forced to zero, and `mem_we_o` is 1.
- R2: Byte address A sits in lane A[1:0], which is bits 8*k+7:8*k of the data bus. An accepted aligned store asserts exactly two byte enables: 4'b0011 when effective-address bit 1 is 0, and 4'b1100 when it is 1. When no write is issued, `mem_be_o` is 4'b0000.
- R3: With `big_end_i` = 0 (little-endian), source bits 7:0 go to the effective address and bits 15:8 go to address+1.
- R4: With `big_end_i` = 1 (big-endian), source bits 15:8 go to the effective address and bits 7:0 go to address+1. The 16-bit lane pair appears in both halves of `mem_wdata_o`.
- R5: If `issue_i` is 0, or bit 0 of `guard_i` is 0, the operation has no effect: no write, no change to the flag, no pending trap. Guard bits 31:1 and source bits 31:16 are ignored.
- R6: An accepted store to an odd effective address writes nothing. It sets `mis_flag_o` one cycle later.
- R7: `mis_flag_o` stays set until `flag_clr_i` is pulsed. If a new misaligned store and a clear arrive in the same cycle, the flag ends up set.
- R8: A misaligned store with `trap_en_i` = 1 leaves a trap pending, and no trap is raised yet. The cycle after an `ijump_i` strobe finds a trap pending, `trap_req_o` is high for exactly one cycle. A misaligned store with `trap_en_i` = 0, or a jump with nothing pending, produces no trap.
- R9: During and just after reset, `mem_we_o`, `mem_be_o`, `mis_flag_o` and `trap_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Store operation presented this cycle |
| guard_i | input | 32 | Guard word; only bit 0 is used |
| base_i | input | 32 | Base byte address |
| src_i | input | 32 | Source operand; bits 15:0 are stored |
| mod_i | input | 7 | Signed halfword displacement count |
| big_end_i | input | 1 | 1 = big-endian, 0 = little-endian |
| trap_en_i | input | 1 | Enable trap on a misaligned store |
| flag_clr_i | input | 1 | Clears the misaligned-store flag |
| ijump_i | input | 1 | Interruptible-jump strobe |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Write data |
| mis_flag_o | output | 1 | Sticky misaligned-store flag |
| trap_req_o | output | 1 | One-cycle exception request |

## Verification
A wrong effective address, wrong lane selection or swapped byte order shows up on the memory outputs in the very cycle after issue. The bench sweeps every displacement against bases of every low-bit pattern, including bases that wrap past the top of the address space, in both byte orders and with both guard values. An error in the flag or the pending-trap state can only be seen indirectly: a flag error appears on `mis_flag_o` one cycle after the store or the clear, and a pending-trap error appears on `trap_req_o` one cycle after a jump strobe. For this reason the bench pairs each trap scenario with idle cycles followed by a jump.

// File: rtl/hstore_pkg.sv
package hstore_pkg;
   typedef enum logic {
      ORD_LITTLE = 1'b0,
      ORD_BIG    = 1'b1
   } byte_order_e;

   localparam int HALF_W = 16;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/hstore_agen.sv
module hstore_agen #(
   parameter int ADDR_W = 32,
   parameter int MOD_W  = 7
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [MOD_W-1:0]  mod_i,
   output logic [ADDR_W-1:0] ea_o
);
   localparam int EXT_W = ADDR_W - MOD_W - 1;

   if (EXT_W < 1) begin : g_bad_width
      $error("hstore_agen: ADDR_W must exceed MOD_W+1");
   end

   logic [ADDR_W-1:0] disp;

   // signed halfword count -> byte displacement
   assign disp = {{EXT_W{mod_i[MOD_W-1]}}, mod_i, 1'b0};
   assign ea_o = base_i + disp;
endmodule

// File: rtl/hstore_lanes.sv
module hstore_lanes
   import hstore_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int SEL_W = $clog2(LANES),
   localparam int HS_W  = SEL_W - 1
) (
   input  logic [HALF_W-1:0] half_i,
   input  byte_order_e       order_i,
   input  logic [HS_W-1:0]   slot_i,
   output logic [LANES-1:0]  be_o,
   output logic [DATA_W-1:0] wdata_o
);
   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("hstore_lanes: DATA_W must be a power of two of at least 32");
   end

   logic [BYTE_W-1:0] at_ea;
   logic [BYTE_W-1:0] at_ea1;
   logic [HALF_W-1:0] pair;

   always_comb begin
      if (order_i == ORD_BIG) begin
         at_ea  = half_i[15:8];
         at_ea1 = half_i[7:0];
      end else begin
         at_ea  = half_i[7:0];
         at_ea1 = half_i[15:8];
      end
      pair = {at_ea1, at_ea};
   end

   for (genvar h = 0; h < LANES / 2; h++) begin : g_half
      assign wdata_o[h*HALF_W +: HALF_W] = pair;
      assign be_o[2*h +: 2] = (slot_i == HS_W'(h)) ? 2'b11 : 2'b00;
   end
endmodule

// File: rtl/hstore_status.sv
module hstore_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic trap_en_i,
   input  logic clr_i,
   input  logic ijump_i,
   output logic flag_o,
   output logic trap_o
);
   logic flag_q;
   logic pend_q;
   logic trap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         pend_q <= 1'b0;
         trap_q <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~clr_i) | set_i;
         pend_q <= (pend_q & ~ijump_i) | (set_i & trap_en_i);
         trap_q <= pend_q & ijump_i;
      end
   end

   assign flag_o = flag_q;
   assign trap_o = trap_q;

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr_i |=> flag_q);

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);

   p_trap_after_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |-> $past(ijump_i));
endmodule

// File: rtl/hstore_unit.sv
module hstore_unit
   import hstore_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int MOD_W  = 7,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [DATA_W-1:0] guard_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [MOD_W-1:0]  mod_i,
   input  logic              big_end_i,
   input  logic              trap_en_i,
   input  logic              flag_clr_i,
   input  logic              ijump_i,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [LANES-1:0]  mem_be_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mis_flag_o,
   output logic              trap_req_o
);
   if (ADDR_W <= SEL_W) begin : g_bad_addr
      $error("hstore_unit: ADDR_W too small for DATA_W");
   end

   logic              unused_bits;
   logic [ADDR_W-1:0] ea;
   logic [LANES-1:0]  be_c;
   logic [DATA_W-1:0] wdata_c;
   logic              accept;
   logic              wr_ok;
   logic              mis;
   byte_order_e       order;

   assign unused_bits = ^{guard_i[DATA_W-1:1], src_i[DATA_W-1:HALF_W]};
   assign order  = big_end_i ? ORD_BIG : ORD_LITTLE;
   assign accept = issue_i & guard_i[0];
   assign wr_ok  = accept & ~ea[0];
   assign mis    = accept & ea[0];

   hstore_agen #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) agen_i (
      .base_i (base_i),
      .mod_i  (mod_i),
      .ea_o   (ea)
   );

   hstore_lanes #(.DATA_W(DATA_W)) lanes_i (
      .half_i  (src_i[HALF_W-1:0]),
      .order_i (order),
      .slot_i  (ea[SEL_W-1:1]),
      .be_o    (be_c),
      .wdata_o (wdata_c)
   );

   hstore_status status_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (mis),
      .trap_en_i (trap_en_i),
      .clr_i     (flag_clr_i),
      .ijump_i   (ijump_i),
      .flag_o    (mis_flag_o),
      .trap_o    (trap_req_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we_o    <= 1'b0;
         mem_be_o    <= '0;
         mem_addr_o  <= '0;
         mem_wdata_o <= '0;
      end else begin
         mem_we_o <= wr_ok;
         mem_be_o <= wr_ok ? be_c : '0;
         if (wr_ok) begin
            mem_addr_o  <= {ea[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};
            mem_wdata_o <= wdata_c;
         end
      end
   end

   p_two_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $countones(mem_be_o) == 2);

   p_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(issue_i && guard_i[0]) |-> !mem_we_o && !$rose(mis_flag_o));

   p_misalign_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> !$rose(mis_flag_o));
endmodule

// File: tb/hstore_unit_tb_top.sv
module hstore_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [31:0] guard_i = '0;
   logic [31:0] base_i = '0;
   logic [31:0] src_i = '0;
   logic [6:0]  mod_i = '0;
   logic        big_end_i = 1'b0;
   logic        trap_en_i = 1'b0;
   logic        flag_clr_i = 1'b0;
   logic        ijump_i = 1'b0;
   logic        mem_we_o;
   logic [31:0] mem_addr_o;
   logic [3:0]  mem_be_o;
   logic [31:0] mem_wdata_o;
   logic        mis_flag_o;
   logic        trap_req_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hstore_unit dut_i (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .guard_i(guard_i),
      .base_i(base_i), .src_i(src_i), .mod_i(mod_i), .big_end_i(big_end_i),
      .trap_en_i(trap_en_i), .flag_clr_i(flag_clr_i), .ijump_i(ijump_i),
      .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
      .mem_wdata_o(mem_wdata_o), .mis_flag_o(mis_flag_o), .trap_req_o(trap_req_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // drive one store, return with outputs of that store visible
   task automatic store(input logic [31:0] g, input logic [31:0] b,
                        input logic [31:0] s, input logic [6:0] m,
                        input logic big, input logic ten, input logic clr);
      @(negedge clk);
      issue_i = 1'b1; guard_i = g; base_i = b; src_i = s; mod_i = m;
      big_end_i = big; trap_en_i = ten; flag_clr_i = clr;
      @(negedge clk);
      issue_i = 1'b0; flag_clr_i = 1'b0; trap_en_i = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
      chk(mis_flag_o == 1'b0, "R7 clear", 32'(mis_flag_o), 32'd0);
   endtask

   task automatic jump_expect(input logic exp, input string req);
      @(negedge clk);
      ijump_i = 1'b1;
      @(negedge clk);
      ijump_i = 1'b0;
      chk(trap_req_o == exp, req, 32'(trap_req_o), 32'(exp));
      @(negedge clk);
      chk(trap_req_o == 1'b0, {req, " one-cycle"}, 32'(trap_req_o), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] ea, ex_addr, ex_data, disp, base, src;
      logic [7:0]  b_at, b_at1;
      logic [3:0]  ex_be;
      logic        wr;

      repeat (3) @(negedge clk);
      chk(mem_we_o == 0 && mem_be_o == 0, "R9 reset mem", {28'd0, mem_be_o}, 32'd0);
      chk(mis_flag_o == 0 && trap_req_o == 0, "R9 reset status",
          32'({mis_flag_o, trap_req_o}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_we_o == 0 && mis_flag_o == 0 && trap_req_o == 0, "R9 after reset",
          32'({mem_we_o, mis_flag_o, trap_req_o}), 32'd0);

      // worked cases, big-endian
      store(32'h1, 32'h0000_0CFE, 32'h4433_2211, 7'd1, 1'b1, 1'b0, 1'b0);
      chk(mem_we_o && mem_addr_o == 32'h0D00, "R1 worked addr", mem_addr_o, 32'h0D00);
      chk(mem_be_o == 4'b0011, "R2 worked lanes low", {28'd0, mem_be_o}, 32'h3);
      chk(mem_wdata_o[15:0] == 16'h1122, "R4 worked data", mem_wdata_o, 32'h1122_1122);
      store(32'h1, 32'h0000_0D06, 32'hAABB_CCDD, 7'h7E, 1'b1, 1'b0, 1'b0);
      chk(mem_we_o && mem_addr_o == 32'h0D00, "R1 worked addr 2", mem_addr_o, 32'h0D00);
      chk(mem_be_o == 4'b1100, "R2 worked lanes high", {28'd0, mem_be_o}, 32'hC);
      chk(mem_wdata_o[31:16] == 16'hDDCC, "R4 worked data 2", mem_wdata_o, 32'hDDCC_DDCC);

      // sweep: all modifiers x bases x order x guard
      for (int g = 0; g < 2; g++) begin
         for (int bo = 0; bo < 2; bo++) begin
            for (int bi = 0; bi < 16; bi++) begin
               for (int m = 0; m < 128; m++) begin
                  base = (bi < 8) ? 32'h0000_2000 + 32'(bi) : 32'hFFFF_FFF8 + 32'(bi - 8);
                  src = {16'hBEEF ^ 16'(m * 7), 8'(m * 3 + 1), 8'(bi * 17 + g)};
                  disp = (m >= 64) ? 32'(2 * (m - 128)) : 32'(2 * m);
                  ea = base + disp;
                  wr = (g == 1) && (ea[0] == 1'b0);
                  b_at  = (bo == 1) ? src[15:8] : src[7:0];
                  b_at1 = (bo == 1) ? src[7:0]  : src[15:8];
                  ex_data = {b_at1, b_at, b_at1, b_at};
                  ex_addr = {ea[31:2], 2'b00};
                  ex_be = wr ? (ea[1] ? 4'b1100 : 4'b0011) : 4'b0000;
                  // g==0: set upper guard bits to show they are ignored
                  store((g == 1) ? 32'h1 : 32'hFFFF_FFFE, base, src, 7'(m),
                        1'(bo), 1'b0, 1'b0);
                  chk(mem_we_o == wr, "R1/R5/R6 write enable", 32'(mem_we_o), 32'(wr));
                  chk(mem_be_o == ex_be, "R2 lanes", {28'd0, mem_be_o}, {28'd0, ex_be});
                  if (wr) begin
                     chk(mem_addr_o == ex_addr, "R1 address", mem_addr_o, ex_addr);
                     chk(mem_wdata_o == ex_data, bo ? "R4 big data" : "R3 little data",
                         mem_wdata_o, ex_data);
                  end
                  chk(mis_flag_o == (g == 1 && ea[0]), "R5/R6 flag",
                      32'(mis_flag_o), 32'(g == 1 && ea[0]));
                  chk(trap_req_o == 1'b0, "R8 no trap", 32'(trap_req_o), 32'd0);
                  if (mis_flag_o) clear_flag();
               end
            end
         end
      end

      // R7 sticky across idle cycles, set wins over same-cycle clear
      store(32'h1, 32'h0000_3001, 32'h1234, 7'd0, 1'b0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      chk(mis_flag_o == 1'b1, "R7 sticky", 32'(mis_flag_o), 32'd1);
      clear_flag();
      store(32'h1, 32'h0000_3003, 32'h1234, 7'd2, 1'b0, 1'b0, 1'b1);
      chk(mis_flag_o == 1'b1, "R7 set wins", 32'(mis_flag_o), 32'd1);
      chk(mem_we_o == 1'b0, "R6 no write", 32'(mem_we_o), 32'd0);
      clear_flag();

      // R8 deferred trap
      store(32'h1, 32'h0000_4005, 32'h55AA, 7'd1, 1'b1, 1'b1, 1'b0);
      repeat (3) begin
         @(negedge clk);
         chk(trap_req_o == 1'b0, "R8 deferred", 32'(trap_req_o), 32'd0);
      end
      jump_expect(1'b1, "R8 trap on jump");
      jump_expect(1'b0, "R8 nothing pending");
      clear_flag();
      // trap disabled
      store(32'h1, 32'h0000_4005, 32'h55AA, 7'd1, 1'b1, 1'b0, 1'b0);
      jump_expect(1'b0, "R8 trap disabled");
      clear_flag();
      // false guard: no flag, no pending trap
      store(32'h0, 32'h0000_4005, 32'h55AA, 7'd1, 1'b1, 1'b1, 1'b0);
      chk(mis_flag_o == 1'b0, "R5 guard flag", 32'(mis_flag_o), 32'd0);
      jump_expect(1'b0, "R5 guard trap");
      // no issue: no effect
      @(negedge clk);
      guard_i = 32'h1; base_i = 32'h0000_4005; trap_en_i = 1'b1; issue_i = 1'b0;
      @(negedge clk);
      trap_en_i = 1'b0;
      chk(mem_we_o == 0 && mis_flag_o == 0, "R5 no issue",
          32'({mem_we_o, mis_flag_o}), 32'd0);
      jump_expect(1'b0, "R5 no issue trap");

      finish_run();
   end
endmodule